// File: doc/BRIEF.md
# SIMD modified-immediate expander

This block turns the 8-bit constant carried in a vector move-immediate instruction word into the full 64-bit pattern that the execution stage loads into vector lanes. It pulls the destination register index, the 4-bit mode field, the op bit and the register-width bit out of a 32-bit instruction word. It then expands the split 8-bit immediate with one of several rules: a zero-filled left shift for 32-bit or 16-bit elements, a left shift that fills the vacated low bits with ones, copying the byte into every byte position, a per-bit byte mask, or decoding it as a compact floating-point constant.

The decode path is purely combinational. A parameter adds a registered output stage with a valid flag and one cycle of latency. Recognising the instruction class, copying the element across lanes and reading or writing the register file are left to the surrounding pipeline.

Top module: `simm_expander`

## Requirements
- R1: The destination index output equals instruction bits [4:0], and the wide output equals instruction bit 30 (1 selects a 128-bit vector register, 0 a 64-bit one).
- R2: When mode bit 3 is 0 (mode in bits [15:12], immediate = {bits[18:16], bits[9:5]}), the size code is 2 and the result is the zero-extended immediate shifted left by 8 × mode[2:1].
- R3: When mode[3:2] is 10, the size code is 1 and the result is the immediate shifted left by 8 × mode[1].
- R4: When mode[3:1] is 110, the size code is 2 and the result is the immediate shifted left by 8 (mode[0]=0) or 16 (mode[0]=1), with every vacated low bit set to one.
- R5: When mode is 1110 and op (bit 29) is 0, the size code is 3 and each of the eight result bytes equals the immediate.
- R6: When mode is 1110 and op is 1, the size code is 3 and result byte i is 0xFF if immediate bit i is set and 0x00 otherwise.
- R7: When mode is 1111 and op is 0, the size code is 0 and the result is a single-precision pattern zero-extended to 64 bits: bit 31 = imm[7], bit 30 = NOT imm[6], bits [29:25] = imm[6], bits [24:19] = imm[5:0], lower bits zero.
- R8: When mode is 1111 and op is 1, the size code is 1 and the result is bit 63 = imm[7], bit 62 = NOT imm[6], bits [61:54] = imm[6], bits [53:48] = imm[5:0], lower bits zero.
- R9: With the registered stage (the default), out_valid equals in_valid one clock later, and the data outputs show the decode of the word presented with it.
- R10: While rst_n is low at a clock edge, out_valid and every data output are cleared to zero.
- R11: In a cycle where in_valid is low, the registered data outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word to decode |
| out_valid | output | 1 | Decoded outputs are valid |
| out_rd | output | 5 | Destination vector register index |
| out_size | output | 2 | Element-size code (0 = 8, 1 = 16, 2 = 32, 3 = 64 bits) |
| out_imm | output | 64 | Expanded immediate constant |
| out_wide | output | 1 | 1 = 128-bit register, 0 = 64-bit register |

## Verification
With the default registered stage, every result (index, size, constant, width flag and valid) is due at the first rising edge after the word is presented. The bench changes inputs on falling edges and reads the outputs at the next falling edge, half a cycle after that result edge. The hold check presents a word, drops in_valid while changing the word, and reads the outputs at the following falling edge. The reset check reads the outputs after several reset edges with a valid word on the input. A full sweep over every mode, op value and immediate byte compares against a model written from the requirements.

// File: rtl/simm_pkg.sv
// Shared widths and types for the modified-immediate expander.
// Assumes a 32-bit instruction word and a 64-bit constant result.
package simm_pkg;
    localparam int INSTR_W = 32;
    localparam int IMM_W   = 64;
    localparam int BYTE_W  = 8;
    localparam int N_BYTES = IMM_W / BYTE_W;
    localparam int RD_W    = 5;
    localparam int MODE_W  = 4;
    localparam int SZ_W    = 2;

    // Element-size codes carried on out_size.
    typedef enum logic [SZ_W-1:0] {
        ESZ_8  = 2'd0,
        ESZ_16 = 2'd1,
        ESZ_32 = 2'd2,
        ESZ_64 = 2'd3
    } esize_t;

    // Fields pulled out of the instruction word.
    typedef struct packed {
        logic [RD_W-1:0]   rd;
        logic [MODE_W-1:0] mode;
        logic              op;
        logic              wide;
        logic [BYTE_W-1:0] imm8;
    } ifields_t;

    // Full decode result handed to the output stage.
    typedef struct packed {
        logic [RD_W-1:0]  rd;
        logic [SZ_W-1:0]  size;
        logic [IMM_W-1:0] imm;
        logic             wide;
    } dres_t;
endpackage

// File: rtl/simm_field_split.sv
// Field extractor: slices the instruction word into index, mode, op,
// width flag and the 8-bit immediate whose bits are split across two
// places in the word. Purely combinational; other bits are ignored.
module simm_field_split
    import simm_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output ifields_t           fields
);
    logic unused_bits;

    // Gather the named fields; the immediate high part sits at [18:16].
    always_comb begin : slice_fields
        fields.rd   = instr[4:0];
        fields.mode = instr[15:12];
        fields.op   = instr[29];
        fields.wide = instr[30];
        fields.imm8 = {instr[18:16], instr[9:5]};
    end

    // Bits not used by this decoder are folded into one sink signal.
    assign unused_bits = ^{instr[31], instr[28:19], instr[11:10]};
endmodule

// File: rtl/simm_expand.sv
// Constant expander: builds every candidate expansion of the 8-bit
// immediate in parallel and selects one with the mode field.
// Assumes N_BYTES equals the immediate width (one mask byte per bit).
module simm_expand
    import simm_pkg::*;
(
    input  ifields_t         fields,
    output esize_t           size,
    output logic [IMM_W-1:0] imm
);
    localparam int PAD8  = IMM_W - BYTE_W;
    localparam int FP_SP = 32;

    logic [IMM_W-1:0] rep_v;
    logic [IMM_W-1:0] mask_v;
    logic [IMM_W-1:0] fp_v;
    logic [IMM_W-1:0] sh32_v;
    logic [IMM_W-1:0] sh16_v;
    logic [IMM_W-1:0] ones_v;
    logic [IMM_W-1:0] base_v;
    logic             fa;
    logic             fb;
    logic [5:0]       ftail;

    assign base_v = {{PAD8{1'b0}}, fields.imm8};

    // One lane per byte: a replica of the immediate and a mask byte.
    for (genvar b = 0; b < N_BYTES; b++) begin : g_lane
        assign rep_v[b*BYTE_W +: BYTE_W]  = fields.imm8;
        assign mask_v[b*BYTE_W +: BYTE_W] = {BYTE_W{fields.imm8[b]}};
    end

    // Shifted forms: byte steps for 32-bit and 16-bit elements.
    always_comb begin : shift_forms
        sh32_v = base_v << {fields.mode[2:1], 3'b000};
        sh16_v = base_v << {fields.mode[1], 3'b000};
        if (fields.mode[0]) begin
            ones_v = {{(IMM_W-24){1'b0}}, fields.imm8, 16'hFFFF};
        end else begin
            ones_v = {{(IMM_W-16){1'b0}}, fields.imm8, 8'hFF};
        end
    end

    // Floating-point form: sign, inverted and repeated exponent bit, fraction.
    always_comb begin : float_form
        fa    = fields.imm8[7];
        fb    = fields.imm8[6];
        ftail = fields.imm8[5:0];
        if (fields.op) begin
            fp_v = {fa, ~fb, {8{fb}}, ftail, 48'd0};
        end else begin
            fp_v = {{(IMM_W-FP_SP){1'b0}}, fa, ~fb, {5{fb}}, ftail, 19'd0};
        end
    end

    // Pick the expansion and size code from the mode field.
    always_comb begin : pick_form
        size = ESZ_32;
        imm  = sh32_v;
        casez (fields.mode)
            4'b0???: begin size = ESZ_32; imm = sh32_v; end
            4'b10??: begin size = ESZ_16; imm = sh16_v; end
            4'b110?: begin size = ESZ_32; imm = ones_v; end
            4'b1110: begin
                size = ESZ_64;
                imm  = fields.op ? mask_v : rep_v;
            end
            default: begin
                size = fields.op ? ESZ_16 : ESZ_8;
                imm  = fp_v;
            end
        endcase
    end
endmodule

// File: rtl/simm_out_stage.sv
// Output stage: either a register with a valid bit (REG_OUT = 1) or a
// straight pass-through (REG_OUT = 0). The register loads only on
// in_valid and clears on synchronous active-low reset.
module simm_out_stage
    import simm_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_valid,
    input  dres_t d,
    output logic  q_valid,
    output dres_t q
);
    if (REG_OUT) begin : g_reg
        dres_t q_r;
        logic  v_r;

        // Capture a new result on valid; hold otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_r <= '0;
                v_r <= 1'b0;
            end else begin
                v_r <= in_valid;
                if (in_valid) begin
                    q_r <= d;
                end
            end
        end

        assign q       = q_r;
        assign q_valid = v_r;
    end else begin : g_comb
        logic unused_clk;
        assign unused_clk = clk ^ rst_n;
        assign q          = d;
        assign q_valid    = in_valid;
    end
endmodule

// File: rtl/simm_expander.sv
// Top of the modified-immediate expander: field split, constant
// expansion and an optional one-cycle output register. Assumes the
// caller has already recognised the word as a move-immediate form.
module simm_expander
    import simm_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] instr,
    output logic               out_valid,
    output logic [RD_W-1:0]    out_rd,
    output logic [SZ_W-1:0]    out_size,
    output logic [IMM_W-1:0]   out_imm,
    output logic               out_wide
);
    ifields_t fields;
    esize_t   esz;
    logic [IMM_W-1:0] eimm;
    dres_t    res_d;
    dres_t    res_q;

    simm_field_split u_split (
        .instr  (instr),
        .fields (fields)
    );

    simm_expand u_exp (
        .fields (fields),
        .size   (esz),
        .imm    (eimm)
    );

    // Bundle the decode result for the output stage.
    always_comb begin : pack_result
        res_d.rd   = fields.rd;
        res_d.size = esz;
        res_d.imm  = eimm;
        res_d.wide = fields.wide;
    end

    simm_out_stage #(.REG_OUT(REG_OUT)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .d        (res_d),
        .q_valid  (out_valid),
        .q        (res_q)
    );

    assign out_rd   = res_q.rd;
    assign out_size = res_q.size;
    assign out_imm  = res_q.imm;
    assign out_wide = res_q.wide;

    if (REG_OUT) begin : g_chk
        // R9
        valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
        // R1
        rd_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (out_rd == $past(instr[4:0]) && out_wide == $past(instr[30])));
        // R2
        shift32_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !instr[15]) |=> (out_size == 2'd2 && out_imm[63:32] == 32'd0));
        // R4
        ones_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && instr[15:13] == 3'b110) |=> (out_imm[7:0] == 8'hFF));
        // R5
        byte_rep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && instr[15:12] == 4'hE && !instr[29]) |=> (out_imm[63:56] == out_imm[7:0]));
        // R11
        hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> ($stable(out_imm) && $stable(out_rd) && !out_valid));
    end
endmodule

// File: tb/sim_simm_expander.sv
`timescale 1ns/1ps
module sim_simm_expander;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = 32'd0;
    logic        out_valid;
    logic [4:0]  out_rd;
    logic [1:0]  out_size;
    logic [63:0] out_imm;
    logic        out_wide;
    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    simm_expander u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .out_valid(out_valid), .out_rd(out_rd), .out_size(out_size),
        .out_imm(out_imm), .out_wide(out_wide)
    );

    function automatic logic [31:0] mk(input logic [4:0] rd, input logic [7:0] i8,
                                       input logic [3:0] md, input logic op, input logic q);
        logic [31:0] w;
        w = 32'h0F000C00;
        w[4:0] = rd; w[9:5] = i8[4:0]; w[18:16] = i8[7:5];
        w[15:12] = md; w[29] = op; w[30] = q;
        return w;
    endfunction

    function automatic logic [63:0] ref_imm(input logic [3:0] md, input logic op, input logic [7:0] i8);
        logic [63:0] r;
        r = 64'd0;
        if (!md[3]) r = {56'd0, i8} << (8 * int'(md[2:1]));
        else if (!md[2]) r = {56'd0, i8} << (8 * int'(md[1]));
        else if (!md[1]) r = md[0] ? (({56'd0, i8} << 16) | 64'hFFFF) : (({56'd0, i8} << 8) | 64'hFF);
        else if (!md[0] && !op) begin
            for (int k = 0; k < 8; k++) r[8*k +: 8] = i8;
        end else if (!md[0]) begin
            for (int k = 0; k < 8; k++) r[8*k +: 8] = i8[k] ? 8'hFF : 8'h00;
        end else if (!op) begin
            r[31] = i8[7]; r[30] = ~i8[6]; r[29:25] = {5{i8[6]}}; r[24:19] = i8[5:0];
        end else begin
            r[63] = i8[7]; r[62] = ~i8[6]; r[61:54] = {8{i8[6]}}; r[53:48] = i8[5:0];
        end
        return r;
    endfunction

    function automatic logic [1:0] ref_size(input logic [3:0] md, input logic op);
        if (!md[3]) return 2'd2;
        if (!md[2]) return 2'd1;
        if (!md[1]) return 2'd2;
        if (!md[0]) return 2'd3;
        return {1'b0, op};
    endfunction

    function automatic string tag_of(input logic [3:0] md, input logic op);
        if (!md[3]) return "R2";
        if (!md[2]) return "R3";
        if (!md[1]) return "R4";
        if (!md[0]) return op ? "R6" : "R5";
        return op ? "R8" : "R7";
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one word; outputs are due at the next rising edge, read at the following falling edge.
    task automatic drive(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        instr = w;
        @(negedge clk);
    endtask

    task automatic check_word(input logic [4:0] rd, input logic [7:0] i8,
                              input logic [3:0] md, input logic op, input logic q);
        drive(mk(rd, i8, md, op, q));
        chk(tag_of(md, op), out_imm, ref_imm(md, op, i8));
        chk(tag_of(md, op), {62'd0, out_size}, {62'd0, ref_size(md, op)});
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        in_valid = 1'b1;
        instr = mk(5'd17, 8'hFF, 4'hE, 1'b0, 1'b1);
        repeat (3) @(negedge clk);
        chk("R10", {63'd0, out_valid}, 64'd0);
        chk("R10", out_imm, 64'd0);
        chk("R10", {59'd0, out_rd}, 64'd0);
        chk("R10", {62'd0, out_size}, 64'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_fields;
        drive(mk(5'd31, 8'h12, 4'h0, 1'b0, 1'b1));
        chk("R1", {59'd0, out_rd}, 64'd31);
        chk("R1", {63'd0, out_wide}, 64'd1);
        chk("R9", {63'd0, out_valid}, 64'd1);
        drive(mk(5'd6, 8'h12, 4'h0, 1'b0, 1'b0));
        chk("R1", {59'd0, out_rd}, 64'd6);
        chk("R1", {63'd0, out_wide}, 64'd0);
    endtask

    task automatic t_shift32;
        for (int m = 0; m < 8; m++) check_word(5'd1, 8'hA5, 4'(m), 1'b1, 1'b0);
        drive(mk(5'd1, 8'hA5, 4'h6, 1'b0, 1'b0));
        chk("R2", out_imm, 64'h00000000A5000000);
    endtask

    task automatic t_shift16;
        for (int m = 8; m < 12; m++) check_word(5'd2, 8'h3C, 4'(m), 1'b0, 1'b1);
        drive(mk(5'd2, 8'h3C, 4'hA, 1'b0, 1'b1));
        chk("R3", out_imm, 64'h0000000000003C00);
    endtask

    task automatic t_ones;
        drive(mk(5'd3, 8'h81, 4'hC, 1'b0, 1'b0));
        chk("R4", out_imm, 64'h00000000000081FF);
        chk("R4", {62'd0, out_size}, 64'd2);
        drive(mk(5'd3, 8'h81, 4'hD, 1'b1, 1'b0));
        chk("R4", out_imm, 64'h000000000081FFFF);
    endtask

    task automatic t_repl;
        drive(mk(5'd4, 8'h5A, 4'hE, 1'b0, 1'b1));
        chk("R5", out_imm, 64'h5A5A5A5A5A5A5A5A);
        chk("R5", {62'd0, out_size}, 64'd3);
    endtask

    task automatic t_mask;
        drive(mk(5'd5, 8'h96, 4'hE, 1'b1, 1'b1));
        chk("R6", out_imm, 64'hFF0000FF00FFFF00);
        chk("R6", {62'd0, out_size}, 64'd3);
    endtask

    task automatic t_float;
        drive(mk(5'd7, 8'h70, 4'hF, 1'b0, 1'b0));
        chk("R7", out_imm, 64'h000000003F800000);
        chk("R7", {62'd0, out_size}, 64'd0);
        drive(mk(5'd7, 8'h70, 4'hF, 1'b1, 1'b1));
        chk("R8", out_imm, 64'h3FF0000000000000);
        chk("R8", {62'd0, out_size}, 64'd1);
    endtask

    task automatic t_hold;
        drive(mk(5'd9, 8'h33, 4'hE, 1'b0, 1'b1));
        @(negedge clk);
        in_valid = 1'b0;
        instr = mk(5'd20, 8'hC4, 4'h2, 1'b0, 1'b0);
        @(negedge clk);
        chk("R11", out_imm, 64'h3333333333333333);
        chk("R11", {59'd0, out_rd}, 64'd9);
        chk("R9", {63'd0, out_valid}, 64'd0);
    endtask

    task automatic t_sweep;
        for (int m = 0; m < 16; m++)
            for (int o = 0; o < 2; o++)
                for (int v = 0; v < 256; v++)
                    check_word(5'(v), 8'(v), 4'(m), 1'(o), 1'(v));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        t_reset();
        t_fields();
        t_shift32();
        t_shift16();
        t_ones();
        t_repl();
        t_mask();
        t_float();
        t_hold();
        t_sweep();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule